// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table held in a byte-addressed memory that returns one 32-bit word for each read. The requester presents a virtual address and the physical byte address of the top-level table, using a valid/ready handshake. The walker then issues two reads in order. The first fetches the top-level entry. That entry names the second-level table, and the second read fetches the leaf entry, which names the frame. The walker returns either the physical address or a fault record.

The virtual address splits into three fields. Bits 31:22 are the top-level index, bits 21:12 are the leaf index, and bits 11:0 are the byte offset within a 4096-byte page. Every table entry is 4 bytes. Bit 0 of an entry marks it present. Bits 31:12 hold a frame number, which is either the frame of the next table or the data frame. Bits 11:1 carry no meaning for the walker. Only one walk runs at a time, and a new request is refused until the previous result has been taken.

Top module: `pt_walk_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.
- R2: The first read of a walk goes to byte address `tbl_base + 4*va[31:22]`.
- R3: When the top-level entry has bit 0 set, the second read goes to byte address `{top_entry[31:12], 12'h000} + 4*va[21:12]`.
- R4: When both entries have bit 0 set, the response carries `rsp_fault`=0 and `rsp_paddr` = `{leaf_entry[31:12], va[11:0]}`.
- R5: A top-level entry with bit 0 clear ends the walk with no second read. The response carries `rsp_fault`=1, `rsp_fault_lvl`=0 and `rsp_fault_va` equal to the request address.
- R6: A leaf entry with bit 0 clear ends the walk with `rsp_fault`=1, `rsp_fault_lvl`=1 and `rsp_fault_va` equal to the request address.
- R7: `req_ready` is 0 from the cycle after a request is accepted until the cycle after the response handshake. A `req_valid` in that window starts no walk.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds and its fields do not change.
- R9: A read request stays asserted with a stable address until `mem_rd_valid` returns.
- R10: Entry bits 11:1 have no effect on read addresses or on the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken |
| req_va | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Physical byte address of the top-level table |
| mem_rd_en | output | 1 | Table read request, held until answered |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data returned this cycle |
| mem_rd_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| rsp_fault | output | 1 | Walk hit an entry that is not present |
| rsp_fault_lvl | output | 1 | 0 = top-level entry, 1 = leaf entry |
| rsp_fault_va | output | 32 | Virtual address of the faulting request |

## Verification
Successful walks are run with different index and offset mixes. The extreme all-ones indices expose a wrong shift or a truncated adder. Distinct top and leaf frames expose a swap of the two entry fields. Entries are given junk in bits 11:1 so that a mask error shows up in the addresses. A present/absent pattern is applied at each level in turn, which separates the two fault levels and shows whether a second read leaks out after a top-level fault. A held-off response and a request raised during a busy walk show whether the result is stable and whether a second walk can start while one is in flight.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int DEF_VA_W  = 32;
  localparam int DEF_OFF_W = 12;
  localparam int DEF_IDX_W = 10;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_TOP,
    WK_LEAF,
    WK_DONE,
    WK_FAULT
  } walk_state_t;
endpackage

// File: rtl/pt_entry_dec.sv
module pt_entry_dec #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic [VA_W-1:0]       pte,
  output logic                  pte_present,
  output logic [VA_W-OFF_W-1:0] pte_frame
);
  logic unused_flags;

  assign pte_present  = pte[0];
  assign pte_frame    = pte[VA_W-1:OFF_W];
  assign unused_flags = ^pte[OFF_W-1:1];
endmodule

// File: rtl/pt_walk_seq.sv
module pt_walk_seq
  import pt_walk_pkg::*;
#(
  parameter int VA_W  = DEF_VA_W,
  parameter int OFF_W = DEF_OFF_W,
  parameter int IDX_W = DEF_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_va,
  input  logic [VA_W-1:0]       tbl_base,
  output logic                  mem_rd_en,
  output logic [VA_W-1:0]       mem_rd_addr,
  input  logic                  mem_rd_valid,
  input  logic                  pte_present,
  input  logic [VA_W-OFF_W-1:0] pte_frame,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [VA_W-1:0]       rsp_paddr,
  output logic                  rsp_fault,
  output logic                  rsp_fault_lvl,
  output logic [VA_W-1:0]       rsp_fault_va
);
  localparam int FRAME_W = VA_W - OFF_W;
  localparam int TOP_W   = VA_W - OFF_W - IDX_W;
  localparam int PTE_SH  = 2;

  function automatic logic [VA_W-1:0] entry_addr(input logic [VA_W-1:0] tbl,
                                                 input logic [VA_W-1:0] idx);
    return tbl + (idx << PTE_SH);
  endfunction

  function automatic logic [VA_W-1:0] frame_base(input logic [FRAME_W-1:0] frm);
    return {frm, {OFF_W{1'b0}}};
  endfunction

  walk_state_t        state_q;
  logic [VA_W-1:0]    va_q, base_q, leaf_tbl_q;
  logic [VA_W-1:0]    top_idx, leaf_idx;

  // named events for the checks
  logic req_fire, rsp_fire, in_top, in_leaf, rd_done;
  assign req_fire = req_valid && req_ready;
  assign rsp_fire = rsp_valid && rsp_ready;
  assign in_top   = (state_q == WK_TOP);
  assign in_leaf  = (state_q == WK_LEAF);
  assign rd_done  = mem_rd_en && mem_rd_valid;

  assign top_idx  = VA_W'(va_q[VA_W-1 -: TOP_W]);
  assign leaf_idx = VA_W'(va_q[OFF_W +: IDX_W]);

  assign req_ready   = (state_q == WK_IDLE);
  assign mem_rd_en   = in_top || in_leaf;
  assign mem_rd_addr = in_leaf ? entry_addr(leaf_tbl_q, leaf_idx)
                               : entry_addr(base_q, top_idx);
  assign rsp_valid   = (state_q == WK_DONE) || (state_q == WK_FAULT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= WK_IDLE;
      va_q          <= '0;
      base_q        <= '0;
      leaf_tbl_q    <= '0;
      rsp_paddr     <= '0;
      rsp_fault     <= 1'b0;
      rsp_fault_lvl <= 1'b0;
      rsp_fault_va  <= '0;
    end else begin
      case (state_q)
        WK_IDLE: if (req_fire) begin
          va_q      <= req_va;
          base_q    <= tbl_base;
          rsp_fault <= 1'b0;
          state_q   <= WK_TOP;
        end
        WK_TOP: if (mem_rd_valid) begin
          if (pte_present) begin
            leaf_tbl_q <= frame_base(pte_frame);
            state_q    <= WK_LEAF;
          end else begin
            rsp_paddr     <= '0;
            rsp_fault     <= 1'b1;
            rsp_fault_lvl <= 1'b0;
            rsp_fault_va  <= va_q;
            state_q       <= WK_FAULT;
          end
        end
        WK_LEAF: if (mem_rd_valid) begin
          rsp_fault_va <= va_q;
          if (pte_present) begin
            rsp_paddr     <= frame_base(pte_frame) | VA_W'(va_q[OFF_W-1:0]);
            rsp_fault     <= 1'b0;
            rsp_fault_lvl <= 1'b0;
            state_q       <= WK_DONE;
          end else begin
            rsp_paddr     <= '0;
            rsp_fault     <= 1'b1;
            rsp_fault_lvl <= 1'b1;
            state_q       <= WK_FAULT;
          end
        end
        default: if (rsp_fire) state_q <= WK_IDLE;
      endcase
    end
  end

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);
  // R7
  ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> req_ready && !rsp_valid);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_fault) && $stable(rsp_fault_lvl) && $stable(rsp_fault_va));
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_rd_valid) |=> mem_rd_en && $stable(mem_rd_addr));
  // R5
  top_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_top && rd_done && !pte_present) |=> rsp_valid && rsp_fault
      && !rsp_fault_lvl && !mem_rd_en);
  // R6
  leaf_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_leaf && rd_done && !pte_present) |=> rsp_valid && rsp_fault && rsp_fault_lvl);
  // R4
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_leaf && rd_done && pte_present) |=> rsp_valid && !rsp_fault
      && (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));
  // R3
  leaf_read_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_top && rd_done && pte_present) |=> mem_rd_en
      && (mem_rd_addr[VA_W-1:OFF_W] >= $past(pte_frame)));
endmodule

// File: rtl/pt_walk_top.sv
module pt_walk_top
  import pt_walk_pkg::*;
#(
  parameter int VA_W  = DEF_VA_W,
  parameter int OFF_W = DEF_OFF_W,
  parameter int IDX_W = DEF_IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  input  logic [VA_W-1:0] tbl_base,
  output logic            mem_rd_en,
  output logic [VA_W-1:0] mem_rd_addr,
  input  logic            mem_rd_valid,
  input  logic [VA_W-1:0] mem_rd_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            rsp_fault,
  output logic            rsp_fault_lvl,
  output logic [VA_W-1:0] rsp_fault_va
);
  localparam int FRAME_W = VA_W - OFF_W;

  logic               pte_present;
  logic [FRAME_W-1:0] pte_frame;

  pt_entry_dec #(.VA_W(VA_W), .OFF_W(OFF_W)) u_dec (
    .pte         (mem_rd_data),
    .pte_present (pte_present),
    .pte_frame   (pte_frame)
  );

  pt_walk_seq #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .tbl_base      (tbl_base),
    .mem_rd_en     (mem_rd_en),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rd_valid  (mem_rd_valid),
    .pte_present   (pte_present),
    .pte_frame     (pte_frame),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl),
    .rsp_fault_va  (rsp_fault_va)
  );
endmodule

// File: tb/sim_pt_walk_top.sv
module sim_pt_walk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b0;
  logic [31:0] req_va = '0, tbl_base = '0;
  logic        mem_rd_en, mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_addr, mem_rd_data = '0;
  logic        req_ready, rsp_valid, rsp_fault, rsp_fault_lvl;
  logic [31:0] rsp_paddr, rsp_fault_va;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] pmem [logic [31:0]];
  logic [31:0] rd_log [0:7];
  int          rd_cnt = 0;
  int          mem_wait = 2;
  bit          extra_walk = 1'b0;

  always #5 clk = ~clk;

  pt_walk_top u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: answers each read two cycles after it is seen
  initial forever begin
    @(negedge clk);
    mem_rd_valid = 1'b0;
    if (mem_rd_en) begin
      if (mem_wait == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = pmem.exists(mem_rd_addr) ? pmem[mem_rd_addr] : 32'h0;
        if (rd_cnt < 8) rd_log[rd_cnt] = mem_rd_addr;
        rd_cnt++;
        mem_wait = 2;
      end else mem_wait--;
    end else mem_wait = 2;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  // issue one walk; poke_busy raises req_valid again while walking (R7)
  task automatic walk(input logic [31:0] base, input logic [31:0] va,
                      input int hold, input bit poke_busy);
    int t;
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; tbl_base = base;
    @(negedge clk);
    req_va = 32'hDEAD_BEEF;
    req_valid = poke_busy;
    chk(req_ready == 1'b0, "R7 busy after accept", 32'(req_ready), 32'h0);
    t = 0;
    while (!rsp_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    for (int i = 0; i < hold; i++) begin
      logic [31:0] p0; logic f0;
      p0 = rsp_paddr; f0 = rsp_fault;
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == p0 && rsp_fault == f0, "R8 held response",
          rsp_paddr, p0);
    end
    req_valid = 1'b0;
  endtask

  task automatic take_rsp();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R7 ready after take",
        32'(req_ready), 32'h1);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'h0);
    chk(mem_rd_en == 1'b0, "R1 mem_rd_en", 32'(mem_rd_en), 32'h0);
  endtask

  task automatic t_ok(input logic [31:0] base, input logic [31:0] va,
                      input logic [19:0] top_frm, input logic [19:0] leaf_frm,
                      input int hold);
    logic [31:0] a1, a2;
    a1 = base + {20'h0, va[31:22], 2'b00};
    a2 = {top_frm, 12'h000} + {20'h0, va[21:12], 2'b00};
    pmem[a1] = {top_frm, 11'h5A5, 1'b1};   // junk in bits 11:1 (R10)
    pmem[a2] = {leaf_frm, 11'h2B3, 1'b1};
    walk(base, va, hold, 1'b0);
    chk(rd_cnt == 2, "R3 two reads", 32'(rd_cnt), 32'd2);
    chk(rd_log[0] == a1, "R2 top read address", rd_log[0], a1);
    chk(rd_log[1] == a2, "R3 leaf read address", rd_log[1], a2);
    chk(rsp_fault == 1'b0, "R4 no fault", 32'(rsp_fault), 32'h0);
    chk(rsp_paddr == {leaf_frm, va[11:0]}, "R4 R10 physical address",
        rsp_paddr, {leaf_frm, va[11:0]});
    take_rsp();
  endtask

  task automatic t_top_fault(input logic [31:0] base, input logic [31:0] va);
    logic [31:0] a1;
    a1 = base + {20'h0, va[31:22], 2'b00};
    pmem[a1] = 32'hFFFF_FFFE;
    walk(base, va, 0, 1'b0);
    chk(rd_cnt == 1, "R5 single read", 32'(rd_cnt), 32'd1);
    chk(rsp_fault == 1'b1 && rsp_fault_lvl == 1'b0, "R5 fault level 0",
        {30'h0, rsp_fault, rsp_fault_lvl}, 32'h2);
    chk(rsp_fault_va == va, "R5 fault va", rsp_fault_va, va);
    repeat (4) @(negedge clk);
    chk(rd_cnt == 1 && mem_rd_en == 1'b0, "R5 no second read", 32'(rd_cnt), 32'd1);
    take_rsp();
  endtask

  task automatic t_leaf_fault(input logic [31:0] base, input logic [31:0] va,
                              input logic [19:0] top_frm);
    logic [31:0] a1, a2;
    a1 = base + {20'h0, va[31:22], 2'b00};
    a2 = {top_frm, 12'h000} + {20'h0, va[21:12], 2'b00};
    pmem[a1] = {top_frm, 12'h001};
    pmem[a2] = 32'h1234_5FFE;
    walk(base, va, 0, 1'b0);
    chk(rd_cnt == 2 && rd_log[1] == a2, "R6 leaf read done", rd_log[1], a2);
    chk(rsp_fault == 1'b1 && rsp_fault_lvl == 1'b1, "R6 fault level 1",
        {30'h0, rsp_fault, rsp_fault_lvl}, 32'h3);
    chk(rsp_fault_va == va, "R6 fault va", rsp_fault_va, va);
    take_rsp();
  endtask

  task automatic t_busy(input logic [31:0] base, input logic [31:0] va);
    logic [31:0] a1, a2;
    a1 = base + {20'h0, va[31:22], 2'b00};
    a2 = 32'h0007_7000 + {20'h0, va[21:12], 2'b00};
    pmem[a1] = 32'h0007_7001;
    pmem[a2] = 32'h000C_C001;
    walk(base, va, 1, 1'b1);
    chk(rsp_paddr == {20'h000CC, va[11:0]}, "R7 first request kept",
        rsp_paddr, {20'h000CC, va[11:0]});
    take_rsp();
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0 && rd_cnt == 2, "R7 no extra walk", 32'(rd_cnt), 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ok(32'h0010_0000, 32'h0040_3ABC, 20'h00200, 20'h12345, 0);
    t_ok(32'h0020_0000, 32'hFFFF_FFFF, 20'h00300, 20'hABCDE, 3);
    t_ok(32'h0030_0000, 32'h0000_0000, 20'h00400, 20'h00001, 0);
    t_ok(32'h0040_0000, 32'hA5C3_3F0F, 20'hFFFFF, 20'h5A5A5, 2);
    t_top_fault(32'h0050_0000, 32'h8020_1004);
    t_leaf_fault(32'h0060_0000, 32'h1234_5678, 20'h00600);
    t_busy(32'h0070_0000, 32'h00C0_2FF0);
    summary();
  end
endmodule